// File: doc/BRIEF.md
# In-Order Retirement and Trap Controller

This block decides, cycle by cycle, which of the oldest instructions in one thread's reorder buffer retire. It looks at up to `N` head slots in program order and retires a contiguous run that starts at the oldest slot. The run ends at the first slot that is empty, that must wait for serialisation, or that carries a fault. A faulting head, or an interrupt that is being taken, puts the controller into a trap state. In that state insertion and retirement are blocked. After a fixed latency the controller emits a one-cycle trap-squash pulse, together with the sequence number that the squash refers to, and then returns to running.

The controller also reports occupancy to the earlier stages. It outputs a registered free-entry count. It also outputs a registered "buffer empty" indication, which is held back while stores still wait to write back and for one cycle after a store retires. An external interrupt request is first recognised and flagged as pending. It is taken only once the buffer is empty and no store waits to write back. Taking it pulses an interrupt-clear output and starts a trap. A separate context-squash request is honoured only while no trap is in flight.

Top module: `commit_ctrl`

## Requirements
- R1: In a running cycle with no context request and no interrupt being taken, `retire_o` is a prefix of slots starting at bit 0. Slot i retires only if every older slot retires. The run stops at the first slot that is invalid, blocked by serialisation, or faulting.
- R2: A slot that is non-speculative (`hd_nonspec`) or an uncached load (`hd_uc_load`) may retire only when it is slot 0 and `st_wb_pending` is low. Otherwise retirement stops at that slot.
- R3: A faulting slot that is reached is not retired and starts a trap. `trap_squash_o` pulses high for exactly one cycle, TRAP_LAT cycles after the fault cycle. During that pulse `trap_seq_o` holds the faulting slot's sequence number. The controller runs again in the following cycle.
- R4: While a trap is in flight (from the cycle after it starts up to and including the squash cycle), `insert_ok_o` is low, `retire_o` is zero, and `ctx_req` produces no `ctx_squash_o`.
- R5: When the controller is running, `ctx_req` drives `ctx_squash_o` high in the same cycle. In that cycle it also forces `retire_o` to zero and `insert_ok_o` low. `ctx_squash_o` and `trap_squash_o` are never high together.
- R6: A raised `irq_req` is recognised only in a running cycle without `ctx_req`. `irq_pending_o` then goes high in the next cycle. No recognition happens while a trap is in flight, including its squash cycle.
- R7: With an interrupt pending in a running cycle without `ctx_req`, the interrupt is taken when `rob_count` is 0 and `st_wb_pending` is low. `irq_clear_o` then pulses in that cycle, `irq_pending_o` drops in the next cycle, and a trap starts. Its squash fires TRAP_LAT cycles later with `trap_seq_o` equal to 0.
- R8: `rob_empty_o` in cycle t+1 is high exactly when, in cycle t, `rob_count` was 0, `st_wb_pending` was low, and no store retired in cycle t-1.
- R9: `free_cnt_o` in cycle t+1 equals DEPTH minus `rob_count` of cycle t. During and right after reset, `rob_empty_o` is 1, `free_cnt_o` is DEPTH, and `irq_pending_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hd_valid | input | N | Head slot holds an instruction (bit 0 is oldest) |
| hd_store | input | N | Slot is a store |
| hd_uc_load | input | N | Slot is an uncached load |
| hd_nonspec | input | N | Slot is non-speculative |
| hd_fault | input | N | Slot carries a fault |
| hd_seq | input | N*SEQ_W | Sequence number per slot, slot i at bits i*SEQ_W upward |
| st_wb_pending | input | 1 | Stores still waiting to write back |
| irq_req | input | 1 | External interrupt request |
| ctx_req | input | 1 | Thread-context squash request |
| rob_count | input | CW | Current buffer occupancy |
| retire_o | output | N | Per-slot retire pulse |
| trap_squash_o | output | 1 | One-cycle trap squash |
| trap_seq_o | output | SEQ_W | Sequence number of the trap (0 for interrupt) |
| ctx_squash_o | output | 1 | Context squash accepted |
| irq_pending_o | output | 1 | Interrupt recognised and waiting |
| irq_clear_o | output | 1 | Interrupt taken this cycle |
| rob_empty_o | output | 1 | Buffer truly empty indication |
| free_cnt_o | output | CW | Registered free-entry count |
| insert_ok_o | output | 1 | New instructions may be inserted |

## Verification
The checker watches, every cycle, the retire vector's prefix shape, the ban on faulting or out-of-slot serial retirements, the exclusion of the two squash kinds, and the blocking of insertion during a trap. It also checks the exact squash latency, measured by its own counter, and the suppression of the empty flag two cycles after a store retires. The directed scenarios are needed for the values themselves. They show which slot ends a run, the sequence number carried by the squash, and when an interrupt held off by a trap is recognised. They also show how the interrupt waits for occupancy and store drain, and the exact free-count and empty readings after given occupancies.

// File: rtl/commit_pkg.sv
package commit_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_TRAP = 1'b1
    } cstate_e;

    typedef struct packed {
        logic valid;
        logic store;
        logic uc_load;
        logic nonspec;
        logic fault;
    } slot_attr_t;

    function automatic logic needs_serial(slot_attr_t s);
        return s.nonspec | s.uc_load;
    endfunction

endpackage

// File: rtl/commit_retire_sel.sv
module commit_retire_sel
    import commit_pkg::*;
#(
    parameter int N     = 4,
    parameter int SEQ_W = 8
) (
    input  logic                 en,
    input  logic                 st_pend,
    input  slot_attr_t [N-1:0]   attr,
    input  logic [N*SEQ_W-1:0]   seq,
    output logic [N-1:0]         retire,
    output logic                 fault_hit,
    output logic [SEQ_W-1:0]     fault_seq
);
    logic [N:0]   reach;
    logic [N-1:0] hit;

    assign reach[0] = en;

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic blocked;
        logic fire;
        assign blocked     = needs_serial(attr[i]) && ((i != 0) || st_pend);
        assign fire        = reach[i] && attr[i].valid && !blocked;
        assign retire[i]   = fire && !attr[i].fault;
        assign hit[i]      = fire && attr[i].fault;
        assign reach[i+1]  = retire[i];
    end

    assign fault_hit = |hit;

    always_comb begin
        fault_seq = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) fault_seq = fault_seq | seq[i*SEQ_W +: SEQ_W];
        end
    end
endmodule

// File: rtl/commit_trap_seq.sv
module commit_trap_seq
    import commit_pkg::*;
#(
    parameter int SEQ_W    = 8,
    parameter int TRAP_LAT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SEQ_W-1:0] start_seq,
    output logic             busy,
    output logic             squash,
    output logic [SEQ_W-1:0] seq_q
);
    localparam int CW = $clog2(TRAP_LAT + 1);

    cstate_e       state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            cnt   <= '0;
            seq_q <= '0;
        end else begin
            case (state)
                ST_RUN: begin
                    if (start) begin
                        state <= ST_TRAP;
                        cnt   <= CW'(TRAP_LAT - 1);
                        seq_q <= start_seq;
                    end
                end
                default: begin
                    if (cnt == '0) state <= ST_RUN;
                    else           cnt   <= cnt - 1'b1;
                end
            endcase
        end
    end

    assign busy   = (state == ST_TRAP);
    assign squash = busy && (cnt == '0);
endmodule

// File: rtl/commit_irq_ctl.sv
module commit_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic irq_req,
    input  logic run,
    input  logic ctx_req,
    input  logic rob_zero,
    input  logic st_pend,
    output logic pending,
    output logic take
);
    logic recog;

    assign recog = irq_req && !pending && run && !ctx_req;
    assign take  = pending && run && !ctx_req && rob_zero && !st_pend;

    always_ff @(posedge clk) begin
        if (rst)        pending <= 1'b0;
        else if (take)  pending <= 1'b0;
        else if (recog) pending <= 1'b1;
    end
endmodule

// File: rtl/commit_empty_track.sv
module commit_empty_track #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] rob_count,
    input  logic          st_pend,
    input  logic          store_ret,
    output logic          empty_q,
    output logic [CW-1:0] free_q
);
    logic store_ret_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            store_ret_q <= 1'b0;
            empty_q     <= 1'b1;
            free_q      <= CW'(DEPTH);
        end else begin
            store_ret_q <= store_ret;
            empty_q     <= (rob_count == '0) && !st_pend && !store_ret_q;
            free_q      <= CW'(DEPTH) - rob_count;
        end
    end
endmodule

// File: rtl/commit_ctrl.sv
module commit_ctrl
    import commit_pkg::*;
#(
    parameter int N        = 4,
    parameter int SEQ_W    = 8,
    parameter int DEPTH    = 16,
    parameter int TRAP_LAT = 3,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       hd_valid,
    input  logic [N-1:0]       hd_store,
    input  logic [N-1:0]       hd_uc_load,
    input  logic [N-1:0]       hd_nonspec,
    input  logic [N-1:0]       hd_fault,
    input  logic [N*SEQ_W-1:0] hd_seq,
    input  logic               st_wb_pending,
    input  logic               irq_req,
    input  logic               ctx_req,
    input  logic [CW-1:0]      rob_count,
    output logic [N-1:0]       retire_o,
    output logic               trap_squash_o,
    output logic [SEQ_W-1:0]   trap_seq_o,
    output logic               ctx_squash_o,
    output logic               irq_pending_o,
    output logic               irq_clear_o,
    output logic               rob_empty_o,
    output logic [CW-1:0]      free_cnt_o,
    output logic               insert_ok_o
);
    slot_attr_t [N-1:0] attr;
    logic               trap_busy;
    logic               run;
    logic               irq_take;
    logic               fault_hit;
    logic [SEQ_W-1:0]   fault_seq;
    logic               trap_start;
    logic [SEQ_W-1:0]   start_seq;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            attr[i] = '{valid:   hd_valid[i],
                        store:   hd_store[i],
                        uc_load: hd_uc_load[i],
                        nonspec: hd_nonspec[i],
                        fault:   hd_fault[i]};
        end
    end

    assign run          = !trap_busy;
    assign ctx_squash_o = ctx_req && run;
    assign insert_ok_o  = run && !ctx_req;
    assign irq_clear_o  = irq_take;
    assign trap_start   = fault_hit || irq_take;
    assign start_seq    = irq_take ? '0 : fault_seq;

    commit_retire_sel #(.N(N), .SEQ_W(SEQ_W)) u_sel (
        .en        (run && !ctx_req && !irq_take),
        .st_pend   (st_wb_pending),
        .attr      (attr),
        .seq       (hd_seq),
        .retire    (retire_o),
        .fault_hit (fault_hit),
        .fault_seq (fault_seq)
    );

    commit_trap_seq #(.SEQ_W(SEQ_W), .TRAP_LAT(TRAP_LAT)) u_trap (
        .clk       (clk),
        .rst       (rst),
        .start     (trap_start),
        .start_seq (start_seq),
        .busy      (trap_busy),
        .squash    (trap_squash_o),
        .seq_q     (trap_seq_o)
    );

    commit_irq_ctl u_irq (
        .clk      (clk),
        .rst      (rst),
        .irq_req  (irq_req),
        .run      (run),
        .ctx_req  (ctx_req),
        .rob_zero (rob_count == '0),
        .st_pend  (st_wb_pending),
        .pending  (irq_pending_o),
        .take     (irq_take)
    );

    commit_empty_track #(.DEPTH(DEPTH), .CW(CW)) u_empty (
        .clk       (clk),
        .rst       (rst),
        .rob_count (rob_count),
        .st_pend   (st_wb_pending),
        .store_ret (|(retire_o & hd_store)),
        .empty_q   (rob_empty_o),
        .free_q    (free_cnt_o)
    );
endmodule

// File: rtl/commit_ctrl_chk.sv
module commit_ctrl_chk #(
    parameter int N        = 4,
    parameter int TRAP_LAT = 3,
    parameter int CW       = 5
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  hd_store,
    input logic [N-1:0]  hd_uc_load,
    input logic [N-1:0]  hd_nonspec,
    input logic [N-1:0]  hd_fault,
    input logic          st_wb_pending,
    input logic [CW-1:0] rob_count,
    input logic [N-1:0]  retire_o,
    input logic          trap_squash_o,
    input logic          ctx_squash_o,
    input logic          irq_pending_o,
    input logic          irq_clear_o,
    input logic          rob_empty_o,
    input logic          insert_ok_o,
    input logic          trap_busy
);
    logic [N:0]   ret_ext;
    logic [N-1:0] serial;
    int           busy_cycles;

    assign ret_ext = {1'b0, retire_o};
    assign serial  = hd_nonspec | hd_uc_load;

    always_ff @(posedge clk) begin
        if (rst)            busy_cycles <= 0;
        else if (trap_busy) busy_cycles <= busy_cycles + 1;
        else                busy_cycles <= 0;
    end

    AST_RETIRE_PREFIX: assert property (@(posedge clk) disable iff (rst)
        (ret_ext & (ret_ext + 1'b1)) == '0); // R1

    AST_SERIAL_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (retire_o & serial & ~N'(1)) == '0); // R2

    AST_SERIAL_DRAINED: assert property (@(posedge clk) disable iff (rst)
        (retire_o[0] && serial[0]) |-> !st_wb_pending); // R2

    AST_NO_FAULT_RETIRE: assert property (@(posedge clk) disable iff (rst)
        (retire_o & hd_fault) == '0); // R3

    AST_TRAP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        trap_squash_o |-> (trap_busy && (busy_cycles + 1 == TRAP_LAT))); // R3

    AST_SQUASH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        trap_squash_o |=> !trap_squash_o); // R3

    AST_TRAP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        trap_busy |-> (!insert_ok_o && retire_o == '0 && !ctx_squash_o)); // R4

    AST_SQUASH_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(trap_squash_o && ctx_squash_o)); // R5

    AST_IRQ_TAKE_COND: assert property (@(posedge clk) disable iff (rst)
        irq_clear_o |-> (irq_pending_o && rob_count == '0 && !st_wb_pending)); // R7

    AST_IRQ_TAKE_TRAPS: assert property (@(posedge clk) disable iff (rst)
        irq_clear_o |=> (trap_busy && !irq_pending_o)); // R7

    AST_STORE_HOLDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (|(retire_o & hd_store)) |=> ##1 !rob_empty_o); // R8
endmodule

bind commit_ctrl commit_ctrl_chk #(.N(N), .TRAP_LAT(TRAP_LAT), .CW(CW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .hd_store      (hd_store),
    .hd_uc_load    (hd_uc_load),
    .hd_nonspec    (hd_nonspec),
    .hd_fault      (hd_fault),
    .st_wb_pending (st_wb_pending),
    .rob_count     (rob_count),
    .retire_o      (retire_o),
    .trap_squash_o (trap_squash_o),
    .ctx_squash_o  (ctx_squash_o),
    .irq_pending_o (irq_pending_o),
    .irq_clear_o   (irq_clear_o),
    .rob_empty_o   (rob_empty_o),
    .insert_ok_o   (insert_ok_o),
    .trap_busy     (trap_busy)
);

// File: tb/sim_commit_ctrl.sv
module sim_commit_ctrl;
    localparam int N        = 4;
    localparam int SEQ_W    = 8;
    localparam int DEPTH    = 16;
    localparam int TRAP_LAT = 3;
    localparam int CW       = $clog2(DEPTH + 1);

    logic               clk = 1'b0;
    logic               rst;
    logic [N-1:0]       hd_valid, hd_store, hd_uc_load, hd_nonspec, hd_fault;
    logic [N*SEQ_W-1:0] hd_seq;
    logic               st_wb_pending, irq_req, ctx_req;
    logic [CW-1:0]      rob_count;
    logic [N-1:0]       retire_o;
    logic               trap_squash_o, ctx_squash_o, irq_pending_o, irq_clear_o;
    logic               rob_empty_o, insert_ok_o;
    logic [SEQ_W-1:0]   trap_seq_o;
    logic [CW-1:0]      free_cnt_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    commit_ctrl #(.N(N), .SEQ_W(SEQ_W), .DEPTH(DEPTH), .TRAP_LAT(TRAP_LAT)) u0 (
        .clk(clk), .rst(rst),
        .hd_valid(hd_valid), .hd_store(hd_store), .hd_uc_load(hd_uc_load),
        .hd_nonspec(hd_nonspec), .hd_fault(hd_fault), .hd_seq(hd_seq),
        .st_wb_pending(st_wb_pending), .irq_req(irq_req), .ctx_req(ctx_req),
        .rob_count(rob_count),
        .retire_o(retire_o), .trap_squash_o(trap_squash_o), .trap_seq_o(trap_seq_o),
        .ctx_squash_o(ctx_squash_o), .irq_pending_o(irq_pending_o),
        .irq_clear_o(irq_clear_o), .rob_empty_o(rob_empty_o),
        .free_cnt_o(free_cnt_o), .insert_ok_o(insert_ok_o)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic clr_slots();
        hd_valid = '0; hd_store = '0; hd_uc_load = '0;
        hd_nonspec = '0; hd_fault = '0; hd_seq = '0;
    endtask

    task automatic set_slot(int i, bit st, bit uc, bit ns, bit f, int seq);
        hd_valid[i]   = 1'b1;
        hd_store[i]   = st;
        hd_uc_load[i] = uc;
        hd_nonspec[i] = ns;
        hd_fault[i]   = f;
        hd_seq[i*SEQ_W +: SEQ_W] = SEQ_W'(seq);
    endtask

    task automatic t_reset();
        clr_slots();
        st_wb_pending = 0; irq_req = 0; ctx_req = 0; rob_count = '0;
        rst = 1;
        repeat (3) step();
        rst = 0;
        settle();
        check("R9 empty after reset", rob_empty_o, 1);
        check("R9 free after reset", free_cnt_o, DEPTH);
        check("R9 irq pending after reset", irq_pending_o, 0);
        check("R4 insert ok after reset", insert_ok_o, 1);
        check("R3 no squash after reset", trap_squash_o, 0);
    endtask

    task automatic t_retire_runs();
        @(negedge clk);
        clr_slots(); rob_count = 4;
        for (int i = 0; i < N; i++) set_slot(i, 0, 0, 0, 0, i + 1);
        settle();
        check("R1 all slots retire", retire_o, 4'b1111);
        hd_valid[2] = 1'b0;
        settle();
        check("R1 run stops at invalid slot", retire_o, 4'b0011);
        hd_valid = 4'b1110;
        settle();
        check("R1 empty oldest slot retires none", retire_o, 0);
    endtask

    task automatic t_serial();
        @(negedge clk);
        clr_slots();
        set_slot(0, 0, 0, 1, 0, 5);
        set_slot(1, 0, 0, 0, 0, 6);
        st_wb_pending = 0;
        settle();
        check("R2 nonspec at slot0 drained", retire_o, 4'b0011);
        st_wb_pending = 1;
        settle();
        check("R2 nonspec waits for store drain", retire_o, 0);
        st_wb_pending = 0;
        clr_slots();
        for (int i = 0; i < N; i++) set_slot(i, 0, 0, 0, 0, i);
        hd_uc_load[2] = 1'b1;
        settle();
        check("R2 uncached load in slot2 stalls", retire_o, 4'b0011);
    endtask

    task automatic t_fault_and_held_irq();
        @(negedge clk);
        clr_slots();
        set_slot(0, 0, 0, 0, 0, 8'h20);
        set_slot(1, 0, 0, 0, 1, 8'h21);
        set_slot(2, 0, 0, 0, 0, 8'h22);
        settle();
        check("R3 faulting slot not retired", retire_o, 4'b0001);
        step();
        irq_req = 1; ctx_req = 1;
        for (int k = 1; k <= TRAP_LAT; k++) begin
            settle();
            check("R4 insert blocked in trap", insert_ok_o, 0);
            check("R4 no retire in trap", retire_o, 0);
            check("R4 ctx ignored in trap", ctx_squash_o, 0);
            check("R3 squash timing", trap_squash_o, (k == TRAP_LAT) ? 1 : 0);
            if (k == TRAP_LAT) begin
                check("R3 trap sequence", trap_seq_o, 8'h21);
                check("R5 squashes exclusive", ctx_squash_o & trap_squash_o, 0);
                ctx_req = 0;
                clr_slots();
            end
            step();
        end
        check("R6 no recognition during trap", irq_pending_o, 0);
        check("R3 running after squash", insert_ok_o, 1);
        check("R3 squash single pulse", trap_squash_o, 0);
        rob_count = 2;
        step();
        check("R6 pending after trap ends", irq_pending_o, 1);
        settle();
        check("R7 not taken while occupied", irq_clear_o, 0);
        rob_count = 0; st_wb_pending = 1;
        settle();
        check("R7 not taken while stores pending", irq_clear_o, 0);
        st_wb_pending = 0;
        settle();
        check("R7 interrupt taken", irq_clear_o, 1);
        step();
        irq_req = 0;
        check("R7 pending drops after take", irq_pending_o, 0);
        check("R7 interrupt trap blocks insert", insert_ok_o, 0);
        for (int k = 2; k <= TRAP_LAT; k++) step();
        settle();
        check("R7 interrupt squash fires", trap_squash_o, 1);
        check("R7 interrupt squash sequence", trap_seq_o, 0);
        step();
        check("R7 running again", insert_ok_o, 1);
    endtask

    task automatic t_ctx();
        @(negedge clk);
        clr_slots(); rob_count = 4;
        for (int i = 0; i < N; i++) set_slot(i, 0, 0, 0, 0, i);
        ctx_req = 1;
        settle();
        check("R5 ctx squash accepted", ctx_squash_o, 1);
        check("R5 ctx blocks retire", retire_o, 0);
        check("R5 ctx blocks insert", insert_ok_o, 0);
        check("R5 no trap squash with ctx", trap_squash_o, 0);
        ctx_req = 0;
        settle();
        check("R1 retire resumes after ctx", retire_o, 4'b1111);
    endtask

    task automatic t_empty_free();
        @(negedge clk);
        clr_slots(); rob_count = 1; st_wb_pending = 0;
        set_slot(0, 1, 0, 0, 0, 9);
        settle();
        check("R1 single store retires", retire_o, 4'b0001);
        step();
        clr_slots(); rob_count = 0;
        step();
        check("R8 empty held after store retire", rob_empty_o, 0);
        step();
        check("R8 empty after store settles", rob_empty_o, 1);
        st_wb_pending = 1;
        step();
        check("R8 empty held while stores pending", rob_empty_o, 0);
        st_wb_pending = 0;
        rob_count = 5;
        step();
        check("R8 not empty when occupied", rob_empty_o, 0);
        check("R9 free count tracks occupancy", free_cnt_o, DEPTH - 5);
        rob_count = DEPTH;
        step();
        check("R9 free count at full", free_cnt_o, 0);
        rob_count = 0;
        step();
        check("R9 free count back to depth", free_cnt_o, DEPTH);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_retire_runs();
        t_serial();
        t_fault_and_held_irq();
        t_ctx();
        t_empty_free();
        summary();
    end
endmodule